// File: doc/BRIEF.md
# Write-Through-Read Cartridge Memory Bridge

This block sits on a cartridge whose host can only issue reads. It decodes three 32 KB read windows in a 20-bit address space. One window returns bytes from a program ROM. The second returns bytes from a battery-backed SRAM. The third commits a byte into that SRAM. Because the host never drives data, the byte to be stored travels inside an address. A read in the SRAM read window copies the low eight address bits into a holding latch. A later read in the commit window places the held byte on the data bus as a dummy result and writes it into the SRAM at the offset of that read.

Software stores a byte in two steps. First it reads the read window at an offset whose low byte is the data. Then it reads the commit window at the target offset. A 16-bit value takes two such pairs. Any access to the commit window is a store, including a firmware scan that probes every 2 KB. Such a scan overwrites each probed location with the last held byte. The bus side is combinational. Only the holding latch is clocked, and it has a synchronous active-high reset.

Top module: `rdonly_store_bridge`

## Requirements
- R1: A read (`rd`=1 with `sel_rom`=1) at an address in D0000h–D7FFFh sets `rom_en`=1 and `bus_doe`=1 in the same cycle. `rom_addr` equals address bits [12:0], so the 8 KB ROM repeats four times across the window. `bus_dout` equals `rom_rdata`.
- R2: A read (`rd`=1 with `sel_rdwin`=1) at an address in E0000h–E7FFFh sets `sram_en`=1, `sram_oe`=1, `sram_we`=0 and `bus_doe`=1, with no wait cycle. `sram_addr` is {2'b11, address[14:0]}, so only the top 32 KB of a 128 KB SRAM is used. `bus_dout` equals `sram_rdata`.
- R3: The read in R2 loads address bits [7:0] into the holding latch at the next rising clock edge. At every other edge the latch keeps its value.
- R4: A read (`rd`=1 with `sel_wrwin`=1) at an address in E8000h–EFFFFh drives the held byte on `bus_dout` with `bus_doe`=1. It also sets `sram_en`=1, `sram_we`=1 and `sram_oe`=0, with `sram_wdata` equal to the held byte and `sram_addr` equal to {2'b11, address[14:0]}.
- R5: In no cycle is more than one of these true: `rom_en`, `sram_oe` (SRAM drives the data bus), `sram_we` (latch drives the data bus).
- R6: A synchronous reset clears the holding latch to 00h. A commit-window read made right after reset stores and returns 00h.
- R7: A cycle with `rd`=0, with the address outside D0000h–EFFFFh, or with the select of the addressed window at 0 gives `bus_doe`=0, `rom_en`=0, `sram_en`=0 and `sram_we`=0. In such a cycle the latch and the SRAM contents do not change.
- R8: Each read in the commit window stores the held byte. A scan that reads E8000h, E8800h, … EF800h writes the held byte to SRAM offsets 0000h, 0800h, … 7800h.
- R9: Stores are byte-only. A 16-bit value written as its low byte at offset N and its high byte at N+1 reads back in little-endian order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the holding latch |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Host read address |
| rd | input | 1 | Host read strobe |
| sel_rom | input | 1 | Select for the ROM window |
| sel_rdwin | input | 1 | Select for the SRAM read window |
| sel_wrwin | input | 1 | Select for the SRAM commit window |
| rom_rdata | input | 8 | Byte returned by the ROM |
| sram_rdata | input | 8 | Byte returned by the SRAM |
| bus_dout | output | 8 | Byte driven toward the host |
| bus_doe | output | 1 | Data bus drive enable |
| rom_en | output | 1 | ROM enable |
| rom_addr | output | 13 | ROM address (mirrored offset) |
| sram_en | output | 1 | SRAM chip enable |
| sram_oe | output | 1 | SRAM output enable (SRAM drives the bus) |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 17 | SRAM address, top bits tied high |
| sram_wdata | output | 8 | Byte written into the SRAM |

## Verification
Enables, addresses and `bus_dout` follow the inputs in the same cycle. The bench drives inputs on the falling edge and samples these outputs two time units later, before the next rising edge. Latch capture and the SRAM store occur on the rising edge that ends the read cycle. The bench therefore observes them only through later reads: a commit-window read returns the held byte, and a read-window read returns the stored byte. Requirements that some access has no effect are checked the same way, by reading back the latch and the target location after the ignored access.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int ADDR_W_DEF = 20;
    localparam int PAGE_AW_DEF = 15;
    localparam int ROM_AW_DEF = 13;
    localparam int RAM_AW_DEF = 17;
    localparam int DATA_W_DEF = 8;

    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_ROM  = 2'd1,
        WIN_LOAD = 2'd2,
        WIN_STORE = 2'd3
    } win_e;

    typedef struct packed {
        logic rd;
        logic sel_rom;
        logic sel_load;
        logic sel_store;
    } strobes_t;

endpackage

// File: rtl/rsb_window_decode.sv
module rsb_window_decode
    import rsb_pkg::*;
#(
    parameter int PAGE_W = 5,
    parameter logic [PAGE_W-1:0] ROM_PAGE = 5'h1A,
    parameter logic [PAGE_W-1:0] LOAD_PAGE = 5'h1C,
    parameter logic [PAGE_W-1:0] STORE_PAGE = 5'h1D
) (
    input  logic [PAGE_W-1:0] page,
    input  strobes_t          stb,
    output win_e              win
);

    logic hit_rom, hit_load, hit_store;

    assign hit_rom   = stb.rd && stb.sel_rom   && (page == ROM_PAGE);
    assign hit_load  = stb.rd && stb.sel_load  && (page == LOAD_PAGE);
    assign hit_store = stb.rd && stb.sel_store && (page == STORE_PAGE);

    always_comb begin
        win = WIN_IDLE;
        if (hit_rom) begin
            win = WIN_ROM;
        end else if (hit_load) begin
            win = WIN_LOAD;
        end else if (hit_store) begin
            win = WIN_STORE;
        end
    end

endmodule

// File: rtl/rsb_byte_latch.sv
module rsb_byte_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= din;
        end
    end

endmodule

// File: rtl/rsb_bus_mux.sv
module rsb_bus_mux
    import rsb_pkg::*;
#(
    parameter int W = 8
) (
    input  win_e         win,
    input  logic [W-1:0] rom_rdata,
    input  logic [W-1:0] sram_rdata,
    input  logic [W-1:0] held,
    output logic [W-1:0] dout,
    output logic         doe
);

    always_comb begin
        dout = '0;
        doe  = 1'b0;
        unique case (win)
            WIN_ROM: begin
                dout = rom_rdata;
                doe  = 1'b1;
            end
            WIN_LOAD: begin
                dout = sram_rdata;
                doe  = 1'b1;
            end
            WIN_STORE: begin
                dout = held;
                doe  = 1'b1;
            end
            default: begin
                dout = '0;
                doe  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rdonly_store_bridge.sv
module rdonly_store_bridge
    import rsb_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int PAGE_AW = PAGE_AW_DEF,
    parameter int ROM_AW = ROM_AW_DEF,
    parameter int RAM_AW = RAM_AW_DEF,
    parameter int DATA_W = DATA_W_DEF,
    parameter logic [ADDR_W-1:0] ROM_BASE = 20'hD0000,
    parameter logic [ADDR_W-1:0] LOAD_BASE = 20'hE0000,
    parameter logic [ADDR_W-1:0] STORE_BASE = 20'hE8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              rd,
    input  logic              sel_rom,
    input  logic              sel_rdwin,
    input  logic              sel_wrwin,
    input  logic [DATA_W-1:0] rom_rdata,
    input  logic [DATA_W-1:0] sram_rdata,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              rom_en,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              sram_en,
    output logic              sram_oe,
    output logic              sram_we,
    output logic [RAM_AW-1:0] sram_addr,
    output logic [DATA_W-1:0] sram_wdata
);

    localparam int PAGE_W = ADDR_W - PAGE_AW;
    localparam int TIE_W = RAM_AW - PAGE_AW;

    win_e              win;
    strobes_t          stb;
    logic [DATA_W-1:0] held_byte;
    logic [PAGE_AW-1:0] offset;

    assign stb.rd        = rd;
    assign stb.sel_rom   = sel_rom;
    assign stb.sel_load  = sel_rdwin;
    assign stb.sel_store = sel_wrwin;
    assign offset        = bus_addr[PAGE_AW-1:0];

    rsb_window_decode #(
        .PAGE_W    (PAGE_W),
        .ROM_PAGE  (ROM_BASE[ADDR_W-1:PAGE_AW]),
        .LOAD_PAGE (LOAD_BASE[ADDR_W-1:PAGE_AW]),
        .STORE_PAGE(STORE_BASE[ADDR_W-1:PAGE_AW])
    ) u_decode (
        .page(bus_addr[ADDR_W-1:PAGE_AW]),
        .stb (stb),
        .win (win)
    );

    rsb_byte_latch #(
        .W(DATA_W)
    ) u_latch (
        .clk (clk),
        .rst (rst),
        .load(win == WIN_LOAD),
        .din (bus_addr[DATA_W-1:0]),
        .q   (held_byte)
    );

    rsb_bus_mux #(
        .W(DATA_W)
    ) u_mux (
        .win       (win),
        .rom_rdata (rom_rdata),
        .sram_rdata(sram_rdata),
        .held      (held_byte),
        .dout      (bus_dout),
        .doe       (bus_doe)
    );

    assign rom_en     = (win == WIN_ROM);
    assign rom_addr   = offset[ROM_AW-1:0];
    assign sram_en    = (win == WIN_LOAD) || (win == WIN_STORE);
    assign sram_oe    = (win == WIN_LOAD);
    assign sram_we    = (win == WIN_STORE);
    assign sram_wdata = held_byte;

    generate
        if (TIE_W > 0) begin : g_tie_high
            assign sram_addr = {{TIE_W{1'b1}}, offset};
        end else begin : g_no_tie
            assign sram_addr = offset[RAM_AW-1:0];
        end
    endgenerate

endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
    parameter int ADDR_W = 20,
    parameter int RAM_AW = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd,
    input logic [DATA_W-1:0] bus_dout,
    input logic              bus_doe,
    input logic              rom_en,
    input logic              sram_en,
    input logic              sram_oe,
    input logic              sram_we,
    input logic [RAM_AW-1:0] sram_addr,
    input logic [DATA_W-1:0] sram_wdata,
    input logic [DATA_W-1:0] held_byte
);

    a_r5_one_driver: assert property (@(posedge clk) disable iff (rst)
        $countones({rom_en, sram_oe, sram_we}) <= 1);

    a_r3_capture: assert property (@(posedge clk) disable iff (rst)
        sram_oe |=> held_byte == $past(bus_addr[DATA_W-1:0]));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !sram_oe |=> $stable(held_byte));

    a_r4_commit_drive: assert property (@(posedge clk) disable iff (rst)
        sram_we |-> (bus_doe && bus_dout == held_byte && sram_wdata == held_byte && !sram_oe));

    a_r2_top_bits: assert property (@(posedge clk) disable iff (rst)
        sram_en |-> (sram_addr[RAM_AW-1:RAM_AW-2] == 2'b11));

    a_r7_no_read: assert property (@(posedge clk) disable iff (rst)
        !rd |-> (!bus_doe && !rom_en && !sram_en && !sram_we));

    a_r6_reset_clear: assert property (@(posedge clk)
        rst |=> held_byte == '0);

endmodule

bind rdonly_store_bridge rsb_checker #(
    .ADDR_W(ADDR_W),
    .RAM_AW(RAM_AW),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .rd        (rd),
    .bus_dout  (bus_dout),
    .bus_doe   (bus_doe),
    .rom_en    (rom_en),
    .sram_en   (sram_en),
    .sram_oe   (sram_oe),
    .sram_we   (sram_we),
    .sram_addr (sram_addr),
    .sram_wdata(sram_wdata),
    .held_byte (held_byte)
);

// File: tb/rdonly_store_bridge_tb.sv
module rdonly_store_bridge_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] bus_addr = '0;
    logic        rd = 1'b0;
    logic        sel_rom = 1'b0;
    logic        sel_rdwin = 1'b0;
    logic        sel_wrwin = 1'b0;
    logic [7:0]  rom_rdata;
    logic [7:0]  sram_rdata;
    logic [7:0]  bus_dout;
    logic        bus_doe;
    logic        rom_en;
    logic [12:0] rom_addr;
    logic        sram_en;
    logic        sram_oe;
    logic        sram_we;
    logic [16:0] sram_addr;
    logic [7:0]  sram_wdata;

    logic [7:0]  mem [32768];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rdonly_store_bridge u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .rd        (rd),
        .sel_rom   (sel_rom),
        .sel_rdwin (sel_rdwin),
        .sel_wrwin (sel_wrwin),
        .rom_rdata (rom_rdata),
        .sram_rdata(sram_rdata),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe),
        .rom_en    (rom_en),
        .rom_addr  (rom_addr),
        .sram_en   (sram_en),
        .sram_oe   (sram_oe),
        .sram_we   (sram_we),
        .sram_addr (sram_addr),
        .sram_wdata(sram_wdata)
    );

    function automatic logic [7:0] rom_fn(input logic [12:0] a);
        return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h5A;
    endfunction

    assign rom_rdata  = rom_fn(rom_addr);
    assign sram_rdata = (sram_en && sram_oe) ? mem[sram_addr[14:0]] : 8'hEE;

    always @(posedge clk) begin
        if (sram_en && sram_we && sram_addr[16:15] == 2'b11) begin
            mem[sram_addr[14:0]] <= sram_wdata;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One host read: inputs at falling edge, outputs sampled 2 units later,
    // strobes removed at the next falling edge after the rising edge.
    logic [7:0] s_dout;
    logic       s_doe, s_rom, s_en, s_oe, s_we;
    logic [16:0] s_saddr;
    logic [12:0] s_raddr;

    task automatic host_read(input logic [19:0] a, input bit r, input bit s_r, input bit s_l, input bit s_s);
        @(negedge clk);
        bus_addr = a;
        rd = r;
        sel_rom = s_r;
        sel_rdwin = s_l;
        sel_wrwin = s_s;
        #2;
        s_dout = bus_dout;
        s_doe = bus_doe;
        s_rom = rom_en;
        s_en = sram_en;
        s_oe = sram_oe;
        s_we = sram_we;
        s_saddr = sram_addr;
        s_raddr = rom_addr;
        check($countones({s_rom, s_oe, s_we}) <= 1, "R5 single driver", $countones({s_rom, s_oe, s_we}), 1);
        @(negedge clk);
        rd = 1'b0;
        sel_rom = 1'b0;
        sel_rdwin = 1'b0;
        sel_wrwin = 1'b0;
    endtask

    task automatic rd_window(input logic [19:0] a);
        host_read(a, 1'b1, a[19:15] == 5'h1A, a[19:15] == 5'h1C, a[19:15] == 5'h1D);
    endtask

    task automatic store_byte(input logic [14:0] off, input logic [7:0] val);
        rd_window(20'hE0000 | {12'h000, val});
        rd_window(20'hE8000 | {5'h00, off});
    endtask

    task automatic t_reset;
        rd_window(20'hE8005);
        check(s_doe && s_dout == 8'h00, "R6 latch cleared", s_dout, 8'h00);
        check(s_we && s_en && !s_oe, "R4 commit enables", {s_we, s_en, s_oe}, 3'b110);
        rd_window(20'hE0005);
        check(s_dout == 8'h00, "R6 stored zero after reset", s_dout, 8'h00);
    endtask

    task automatic t_rom;
        rd_window(20'hD0123);
        check(s_rom && s_doe && s_dout == rom_fn(13'h0123), "R1 rom read", s_dout, rom_fn(13'h0123));
        rd_window(20'hD6123);
        check(s_raddr == 13'h0123 && s_dout == rom_fn(13'h0123), "R1 rom mirror", s_raddr, 13'h0123);
        rd_window(20'hD7FFF);
        check(s_dout == rom_fn(13'h1FFF) && !s_en, "R1 rom top", s_dout, rom_fn(13'h1FFF));
    endtask

    task automatic t_store_load;
        store_byte(15'h0123, 8'hA5);
        check(s_dout == 8'hA5 && s_doe, "R4 dummy read returns held", s_dout, 8'hA5);
        check(s_saddr == 17'h18123, "R4 commit address", s_saddr, 17'h18123);
        rd_window(20'hE0123);
        check(s_dout == 8'hA5 && s_oe && !s_we, "R2 sram read", s_dout, 8'hA5);
        check(s_saddr == 17'h18123, "R2 top bits high", s_saddr, 17'h18123);
        rd_window(20'hE8400);
        check(s_dout == 8'h23, "R3 latch took low address byte", s_dout, 8'h23);
        rd_window(20'hE8401);
        check(s_dout == 8'h23, "R3 latch holds", s_dout, 8'h23);
    endtask

    task automatic t_ignored;
        rd_window(20'hE003C);
        host_read(20'hC0011, 1'b1, 1'b1, 1'b1, 1'b1);
        check(!s_doe && !s_rom && !s_en && !s_we, "R7 outside windows", {s_doe, s_rom, s_en, s_we}, 0);
        host_read(20'hE0077, 1'b0, 1'b0, 1'b1, 1'b0);
        check(!s_doe && !s_en, "R7 no strobe", {s_doe, s_en}, 0);
        host_read(20'hE0066, 1'b1, 1'b0, 1'b0, 1'b0);
        check(!s_doe && !s_en, "R7 select low", {s_doe, s_en}, 0);
        host_read(20'hE8700, 1'b1, 1'b0, 1'b0, 1'b0);
        check(!s_we && !s_doe, "R7 commit without select", s_we, 0);
        rd_window(20'hE0700);
        check(s_dout == 8'h00, "R7 sram untouched", s_dout, 8'h00);
        rd_window(20'hE8702);
        check(s_dout == 8'h00, "R7 latch followed only valid read", s_dout, 8'h00);
        rd_window(20'hE003C);
        rd_window(20'hE8703);
        check(s_dout == 8'h3C, "R7 latch unchanged by ignored reads", s_dout, 8'h3C);
    endtask

    task automatic t_word;
        logic [15:0] w;
        store_byte(15'h0200, 8'hEF);
        store_byte(15'h0201, 8'hBE);
        rd_window(20'hE0200);
        w[7:0] = s_dout;
        rd_window(20'hE0201);
        w[15:8] = s_dout;
        check(w == 16'hBEEF, "R9 little-endian word", w, 16'hBEEF);
    endtask

    task automatic t_scan;
        rd_window(20'hE0077);
        for (int k = 0; k < 16; k++) begin
            rd_window(20'hE8000 + k * 20'h00800);
        end
        for (int k = 0; k < 16; k++) begin
            rd_window(20'hE0000 + k * 20'h00800);
            check(s_dout == 8'h77, $sformatf("R8 scan corrupted slot %0d", k), s_dout, 8'h77);
        end
    endtask

    initial begin
        for (int i = 0; i < 32768; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rom();
        t_store_load();
        t_ignored();
        t_word();
        t_scan();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule